// File: doc/BRIEF.md
# Keystream XOR Decryptor

This block decrypts a short message with a byte-wide stream cipher of the swap-and-index kind. Its state memory must already hold a key-scheduled permutation of 0..255 when a request arrives. The block walks two indices over that memory and swaps two entries for every character. It then looks up one pad byte per character and XORs it with the ciphertext character. The plaintext is written to a separate RAM.

Messages are length-prefixed. Address 0 holds the character count, and the characters follow at addresses 1 and up. The count is not encrypted, so the block copies it through unchanged. The state memory has a single port, so each swap is done as a sequence of reads and writes.

A caller starts the block with a one-cycle `en` pulse while `rdy` is high, and presents a 24-bit key argument in that same cycle. The block then keeps `rdy` low until it has written the last plaintext byte. All three memories are 256 words of 8 bits, and their reads are combinational.

Top module: `keystream_xor_decryptor`

## Requirements
- R1: After synchronous reset, `rdy` is 1 and neither `s_wren` nor `pt_wren` is asserted.
- R2: `en` may be asserted only while `rdy` is 1, and `key` must be valid in that cycle. In the cycle after an accepted `en`, `rdy` is 0.
- R3: The byte at ciphertext address 0 (the count n, 0..255) is written unchanged to plaintext address 0. This is the first plaintext write of the request.
- R4: When n = 0, the block writes only plaintext address 0, does not modify the state memory, and returns to ready.
- R5: For each character, with i and j both starting at 0 per request, the block sets i = i+1 and then j = j+S[i] (both mod 256) and swaps S[i] with S[j]. The state memory is left holding the updated permutation.
- R6: For k = 1..n, the byte at plaintext address k equals the byte at ciphertext address k XOR S[(S[i]+S[j]) mod 256], read after that character's swap. Writes go to strictly increasing addresses.
- R7: No plaintext address greater than n is written.
- R8: `rdy` returns to 1 only after the last plaintext write. A request makes exactly n+1 plaintext writes and keeps `rdy` low for 5n+1 cycles.
- R9: While `rdy` is 1, the block writes neither the state memory nor the plaintext memory.
- R10: A request issued immediately after the previous one finishes restarts i and j at 0. It operates on the state left behind by the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Request strobe, legal only while `rdy` is 1 |
| key | input | 24 | Key argument, valid in the same cycle as `en` |
| rdy | output | 1 | Ready to accept a request in this cycle |
| s_addr | output | 8 | State memory address |
| s_wdata | output | 8 | State memory write data |
| s_wren | output | 1 | State memory write enable |
| s_rdata | input | 8 | State memory read data (combinational) |
| ct_addr | output | 8 | Ciphertext ROM address |
| ct_rdata | input | 8 | Ciphertext ROM read data (combinational) |
| pt_addr | output | 8 | Plaintext RAM address |
| pt_wdata | output | 8 | Plaintext RAM write data |
| pt_wren | output | 1 | Plaintext RAM write enable |

## Verification
The bench targets these corner cases:
- **Empty message.** A design that skipped the zero check would run one character and corrupt the state.
- **Full 255-character message.** A design with an off-by-one on the last index would write one byte too many or too few, or wrap the character counter.
- **Draws where i equals j.** These are common on random permutations. A design that read S[j] before the S[i] write, or that looked up the pad before the swap finished, would produce wrong pad bytes and a wrong final permutation.
- **Back-to-back requests with no re-initialisation.** A design that carried i or j over between requests would diverge at the first character.

// File: rtl/kx_pkg.sv
package kx_pkg;

    // Width of an index and of a data byte; the state memory depth is 2**KX_W.
    localparam int KX_W = 8;

    // One phase per single-port access of the character loop.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEN,
        PH_RD_I,
        PH_RD_J,
        PH_WR_I,
        PH_WR_J,
        PH_PAD
    } kx_phase_e;

    // Number of busy cycles for a message of n characters.
    function automatic int kx_busy_cycles(input int n);
        return 5 * n + 1;
    endfunction

endpackage

// File: rtl/kx_seq.sv
module kx_seq
    import kx_pkg::*;
#(
    parameter int W = KX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] s_rdata,
    input  logic [W-1:0] ct_rdata,
    output kx_phase_e    phase,
    output logic [W-1:0] i_q,
    output logic [W-1:0] j_q,
    output logic [W-1:0] si_q,
    output logic [W-1:0] sj_q,
    output logic [W-1:0] k_q,
    output logic         rdy
);

    logic [W-1:0] len_q;

    assign rdy = (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            i_q   <= '0;
            j_q   <= '0;
            si_q  <= '0;
            sj_q  <= '0;
            k_q   <= '0;
            len_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (en) phase <= PH_LEN;
                PH_LEN: begin
                    len_q <= ct_rdata;
                    i_q   <= '0;
                    j_q   <= '0;
                    k_q   <= W'(1);
                    phase <= (ct_rdata == '0) ? PH_IDLE : PH_RD_I;
                end
                PH_RD_I: begin
                    si_q  <= s_rdata;
                    i_q   <= i_q + W'(1);
                    phase <= PH_RD_J;
                end
                PH_RD_J: begin
                    sj_q  <= s_rdata;
                    j_q   <= j_q + si_q;
                    phase <= PH_WR_I;
                end
                PH_WR_I: phase <= PH_WR_J;
                PH_WR_J: phase <= PH_PAD;
                PH_PAD: begin
                    if (k_q == len_q) begin
                        phase <= PH_IDLE;
                    end else begin
                        k_q   <= k_q + W'(1);
                        phase <= PH_RD_I;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R2: a request is only legal while ready
    p_en_legal_r2: assert property (@(posedge clk) disable iff (rst)
        en |-> rdy);

    // R2: ready drops in the cycle after an accepted request
    p_rdy_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (en && rdy) |=> !rdy);

    // R7: a pad cycle only ever addresses a character inside the message
    p_pad_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAD) |-> (k_q != '0 && k_q <= len_q));

    // R6: characters advance by exactly one between pad cycles
    p_char_step_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAD && k_q != len_q) |=> (k_q == $past(k_q) + W'(1)));

endmodule

// File: rtl/kx_port.sv
module kx_port
    import kx_pkg::*;
#(
    parameter int W = KX_W
) (
    input  kx_phase_e    phase,
    input  logic [W-1:0] i_q,
    input  logic [W-1:0] j_q,
    input  logic [W-1:0] si_q,
    input  logic [W-1:0] sj_q,
    input  logic [W-1:0] k_q,
    input  logic [W-1:0] s_rdata,
    input  logic [W-1:0] ct_rdata,
    output logic [W-1:0] s_addr,
    output logic [W-1:0] s_wdata,
    output logic         s_wren,
    output logic [W-1:0] ct_addr,
    output logic [W-1:0] pt_addr,
    output logic [W-1:0] pt_wdata,
    output logic         pt_wren
);

    always_comb begin
        s_addr   = '0;
        s_wdata  = '0;
        s_wren   = 1'b0;
        ct_addr  = '0;
        pt_addr  = '0;
        pt_wdata = '0;
        pt_wren  = 1'b0;
        unique case (phase)
            PH_LEN: begin
                pt_wdata = ct_rdata;
                pt_wren  = 1'b1;
            end
            PH_RD_I: s_addr = i_q + W'(1);
            PH_RD_J: s_addr = j_q + si_q;
            PH_WR_I: begin
                s_addr  = i_q;
                s_wdata = sj_q;
                s_wren  = 1'b1;
            end
            PH_WR_J: begin
                s_addr  = j_q;
                s_wdata = si_q;
                s_wren  = 1'b1;
            end
            PH_PAD: begin
                s_addr   = si_q + sj_q;
                ct_addr  = k_q;
                pt_addr  = k_q;
                pt_wdata = s_rdata ^ ct_rdata;
                pt_wren  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/keystream_xor_decryptor.sv
module keystream_xor_decryptor
    import kx_pkg::*;
#(
    parameter int W   = KX_W,
    parameter int KEY_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [KEY_W-1:0] key,
    output logic             rdy,
    output logic [W-1:0]     s_addr,
    output logic [W-1:0]     s_wdata,
    output logic             s_wren,
    input  logic [W-1:0]     s_rdata,
    output logic [W-1:0]     ct_addr,
    input  logic [W-1:0]     ct_rdata,
    output logic [W-1:0]     pt_addr,
    output logic [W-1:0]     pt_wdata,
    output logic             pt_wren
);

    kx_phase_e    phase;
    logic [W-1:0] i_q, j_q, si_q, sj_q, k_q;

    kx_seq #(.W(W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .s_rdata  (s_rdata),
        .ct_rdata (ct_rdata),
        .phase    (phase),
        .i_q      (i_q),
        .j_q      (j_q),
        .si_q     (si_q),
        .sj_q     (sj_q),
        .k_q      (k_q),
        .rdy      (rdy)
    );

    kx_port #(.W(W)) u_port (
        .phase    (phase),
        .i_q      (i_q),
        .j_q      (j_q),
        .si_q     (si_q),
        .sj_q     (sj_q),
        .k_q      (k_q),
        .s_rdata  (s_rdata),
        .ct_rdata (ct_rdata),
        .s_addr   (s_addr),
        .s_wdata  (s_wdata),
        .s_wren   (s_wren),
        .ct_addr  (ct_addr),
        .pt_addr  (pt_addr),
        .pt_wdata (pt_wdata),
        .pt_wren  (pt_wren)
    );

    // R2: the key argument is valid alongside an accepted request
    always_ff @(posedge clk) begin
        if (!rst && en && rdy) begin
            p_key_known_r2: assert (!$isunknown(key));
        end
    end

    // R9: no memory is written while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        rdy |-> (!s_wren && !pt_wren));

    // R8: ready only comes back right after a plaintext write
    p_rdy_after_write_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(pt_wren));

    // R3: the first cycle of a request copies the count to plaintext address 0
    p_len_first_r3: assert property (@(posedge clk) disable iff (rst)
        (en && rdy) |=> (pt_wren && pt_addr == '0 && ct_addr == '0));

endmodule

// File: tb/keystream_xor_decryptor_tb.sv
`timescale 1ns/1ps
module keystream_xor_decryptor_tb;
    localparam int N = 256;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst, en;
    logic [23:0] key;
    logic        rdy, s_wren, pt_wren;
    logic [7:0]  s_addr, s_wdata, s_rdata, ct_addr, ct_rdata, pt_addr, pt_wdata;

    logic [7:0] s_mem  [N];
    logic [7:0] ct_mem [N];
    logic [7:0] pt_mem [N];
    logic [7:0] ref_s  [N];
    logic [7:0] ref_pt [N];

    int checks = 0, errors = 0;
    int wr_cnt, exp_addr, order_err, range_err, idle_err, cur_len;

    keystream_xor_decryptor u_dut (
        .clk(clk), .rst(rst), .en(en), .key(key), .rdy(rdy),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_wren(s_wren), .s_rdata(s_rdata),
        .ct_addr(ct_addr), .ct_rdata(ct_rdata),
        .pt_addr(pt_addr), .pt_wdata(pt_wdata), .pt_wren(pt_wren)
    );

    assign s_rdata  = s_mem[s_addr];
    assign ct_rdata = ct_mem[ct_addr];

    always @(posedge clk) begin
        if (s_wren)  s_mem[s_addr]  <= s_wdata;
        if (pt_wren) pt_mem[pt_addr] <= pt_wdata;
    end

    // Port monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (pt_wren) begin
                wr_cnt++;
                if (int'(pt_addr) != exp_addr) order_err++;
                exp_addr = int'(pt_addr) + 1;
                if (int'(pt_addr) > cur_len) range_err++;
            end
            if (rdy && (s_wren || pt_wren)) idle_err++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic shuffle_state();
        for (int a = 0; a < N; a++) s_mem[a] = 8'(a);
        for (int a = N - 1; a > 0; a--) begin
            int b;
            logic [7:0] t;
            b = $urandom_range(0, a);
            t = s_mem[a]; s_mem[a] = s_mem[b]; s_mem[b] = t;
        end
    endtask

    // Bench reference of the keystream and XOR
    task automatic compute_ref(input int n);
        logic [7:0] i, j, t;
        for (int a = 0; a < N; a++) ref_s[a] = s_mem[a];
        ref_pt[0] = 8'(n);
        i = 0; j = 0;
        for (int k = 1; k <= n; k++) begin
            i = i + 8'd1;
            j = j + ref_s[i];
            t = ref_s[i]; ref_s[i] = ref_s[j]; ref_s[j] = t;
            ref_pt[k] = ct_mem[k] ^ ref_s[8'(ref_s[i] + ref_s[j])];
        end
    endtask

    // Called at a negedge with rdy high; returns at the negedge rdy is seen again.
    task automatic run_req(input int n, input bit fresh, input string tag);
        int busy, bad_pt, bad_s;
        if (fresh) shuffle_state();
        for (int a = 0; a < N; a++) begin
            ct_mem[a] = 8'($urandom);
            pt_mem[a] = 8'hA5;
        end
        ct_mem[0] = 8'(n);
        compute_ref(n);
        wr_cnt = 0; exp_addr = 0; order_err = 0; range_err = 0; idle_err = 0; cur_len = n;
        chk(rdy === 1'b1, {tag, " R2 ready before request"}, int'(rdy), 1);
        en  = 1'b1;
        key = 24'($urandom);
        @(negedge clk);
        en  = 1'b0;
        key = 'x;
        chk(rdy === 1'b0, {tag, " R2 rdy low after en"}, int'(rdy), 0);
        busy = 0;
        do begin
            busy++;
            @(negedge clk);
        end while (!rdy && busy < 5000);
        chk(busy == kx_pkg::kx_busy_cycles(n), {tag, " R8 busy cycles"}, busy, kx_pkg::kx_busy_cycles(n));
        chk(wr_cnt == n + 1, {tag, " R8 plaintext write count"}, wr_cnt, n + 1);
        chk(pt_mem[0] == 8'(n), {tag, " R3 length byte"}, int'(pt_mem[0]), n);
        bad_pt = 0;
        for (int k = 1; k <= n; k++) if (pt_mem[k] !== ref_pt[k]) bad_pt++;
        chk(bad_pt == 0, {tag, " R6 plaintext mismatches"}, bad_pt, 0);
        chk(order_err == 0, {tag, " R6 write order errors"}, order_err, 0);
        chk(range_err == 0, {tag, " R7 out-of-range writes"}, range_err, 0);
        if (n < N - 1)
            chk(pt_mem[n + 1] == 8'hA5, {tag, " R7 byte past message"}, int'(pt_mem[n + 1]), 'hA5);
        bad_s = 0;
        for (int a = 0; a < N; a++) if (s_mem[a] !== ref_s[a]) bad_s++;
        chk(bad_s == 0, {tag, (n == 0) ? " R4 state untouched" : " R5 final state mismatches"}, bad_s, 0);
        chk(idle_err == 0, {tag, " R9 writes while idle"}, idle_err, 0);
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog timeout actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; en = 1'b0; key = '0;
        cur_len = 0; wr_cnt = 0; exp_addr = 0; order_err = 0; range_err = 0; idle_err = 0;
        shuffle_state();
        for (int a = 0; a < N; a++) begin ct_mem[a] = 0; pt_mem[a] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rdy === 1'b1, "R1 rdy after reset", int'(rdy), 1);
        chk(s_wren === 1'b0 && pt_wren === 1'b0, "R1 no writes after reset",
            int'({s_wren, pt_wren}), 0);
        repeat (2) @(negedge clk);
        chk(idle_err == 0, "R9 idle after reset", idle_err, 0);

        run_req(0,   1'b1, "empty R4");
        run_req(1,   1'b1, "single");
        run_req(255, 1'b1, "full");
        for (int r = 0; r < 6; r++) run_req($urandom_range(2, 254), 1'b1, "random");
        // R10: back-to-back on the state left behind, no idle gap
        run_req(40, 1'b0, "chain R10");
        run_req(17, 1'b0, "chain R10");
        run_req(0,  1'b0, "chain R10 R4");
        run_req(3,  1'b0, "chain R10");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule